// File: doc/BRIEF.md
# Legacy Interrupt Routing Matrix

This block decides what drives each of the sixteen request lines of a legacy programmable interrupt controller. Each line has a legacy source by default: its external IRQ pin ORed with its decoded serial IRQ slot. A small configuration store can instead steer one or more routable sources onto any line. The routable sources are the four PCI interrupt pins, three plug-and-play pins and the system-control interrupt. Once a line has a routable source, its legacy sources are cut off and the line is flagged as level-type.

Two lines near the top of the map can be switched to native disk mode. In that mode they carry a drive interrupt, merged with any routed source, as an active-low level request. The keyboard and mouse lines have an extra step. Their pin and serial slot values are ANDed and sent out to an emulation unit, and the value that unit returns becomes the legacy source of each of those lines. The configuration store is registered. All routing from inputs to outputs is combinational.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every select field, every system-control bit and both native bits are 0. Every line without routing drives `pic_req[n] = ext_irq[n] | ser_irq[n]` with `pic_level[n]=0` and `pic_act_low[n]=0`. Lines 1 and 12 are the exception, see R9.
- R2: A cycle with `cfg_wr_en=1` stores `cfg_wr_sel` and `cfg_wr_sci` for line `cfg_wr_line` at the rising edge. The new routing is visible from that edge onward, and every other line keeps its setting.
- R3: Select code 0 routes nothing. Codes 1 to 4 route PCI pins A to D (`pci_int_n[0..3]`, active low), so the line is high while the chosen pin is low. Codes 5 to 7 route plug-and-play pins 0 to 2.
- R4: The contribution of plug-and-play pin k is the inverse of `pnp_pin[k]` when `pnp_keep[k]=0`, and equals `pnp_pin[k]` when `pnp_keep[k]=1`.
- R5: When a line's system-control bit is set, an active-high `sci_irq` asserts that line.
- R6: When several routable sources are selected for the same line, the line is high whenever any one of them is active.
- R7: A line with a nonzero select code or a set system-control bit ignores both `ext_irq[n]` and `ser_irq[n]`, and reports `pic_level[n]=1`.
- R8: With its native bit set (bit 0 for line 14, bit 1 for line 15), a line ignores its pin and slot. It drives `pic_req = ~(drv_irq[k] | routed contribution)` with `pic_level=1` and `pic_act_low=1`.
- R9: `kbd_emu_src[0] = ext_irq[1] & ser_irq[1]` and `kbd_emu_src[1] = ext_irq[12] & ser_irq[12]`. The legacy source of line 1 is `kbd_emu_ret[0]`, and the legacy source of line 12 is `kbd_emu_ret[1]`.
- R10: A cycle with `nat_wr_en=1` loads `nat_wr_val` into the native bits at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for one line's routing |
| cfg_wr_line | input | 4 | Line index to write |
| cfg_wr_sel | input | 3 | Select code written |
| cfg_wr_sci | input | 1 | System-control bit written |
| nat_wr_en | input | 1 | Write strobe for native bits |
| nat_wr_val | input | 2 | Native bits for lines 14 and 15 |
| pci_int_n | input | 4 | PCI interrupt pins A to D, active low |
| pnp_pin | input | 3 | Plug-and-play pins |
| pnp_keep | input | 3 | Per-pin polarity keep bits |
| sci_irq | input | 1 | System-control interrupt, active high |
| ext_irq | input | 16 | External IRQ pins |
| ser_irq | input | 16 | Decoded serial IRQ slots |
| drv_irq | input | 2 | Disk drive interrupts for lines 14 and 15 |
| kbd_emu_ret | input | 2 | Returned keyboard and mouse values |
| kbd_emu_src | output | 2 | Merged keyboard and mouse values to emulation |
| pic_req | output | 16 | Request lines to the controller |
| pic_level | output | 16 | Line is a level-type request |
| pic_act_low | output | 16 | Line is active low |

## Verification
Two things can happen in the same cycle: a routing write, and a change on the legacy pin of the line being written. The bench raises both at one falling edge. It checks the line before the next rising edge, where it must still follow the legacy pin. It checks the line again after that edge, where it must ignore the pin and follow the newly routed source. The same approach is used on line 14, where the native switch and a PCI route meet. There the output must be the active-low merge of both sources.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NPCI  = 4;
  localparam int unsigned NPNP  = 3;
  localparam int unsigned SEL_W = 3;

  typedef struct packed {
    logic             sci;
    logic [SEL_W-1:0] sel;
  } line_cfg_t;

  // OR of every routable source that the configuration picks for one line
  function automatic logic route_contrib(line_cfg_t c, logic [NPCI-1:0] pci_act,
                                         logic [NPNP-1:0] pnp_act, logic sci);
    logic r;
    r = c.sci & sci;
    for (int i = 0; i < NPCI; i++)
      if (c.sel == SEL_W'(i + 1)) r = r | pci_act[i];
    for (int i = 0; i < NPNP; i++)
      if (c.sel == SEL_W'(i + 1 + NPCI)) r = r | pnp_act[i];
    return r;
  endfunction

  function automatic logic is_routed(line_cfg_t c);
    return (c.sel != '0) | c.sci;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned NUM_NATIVE = 2,
  localparam int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [LINE_W-1:0]               wr_line,
  input  line_cfg_t                       wr_cfg,
  input  logic                            nat_wr_en,
  input  logic [NUM_NATIVE-1:0]           nat_wr_val,
  output line_cfg_t [NUM_LINES-1:0]       cfg_q,
  output logic [NUM_NATIVE-1:0]           native_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      native_q <= '0;
    end else begin
      if (wr_en) cfg_q[wr_line] <= wr_cfg;
      if (nat_wr_en) native_q <= nat_wr_val;
    end
  end

  assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q[$past(wr_line)] == $past(wr_cfg));
  assert_native_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nat_wr_en |=> native_q == $past(nat_wr_val));
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 16,
  parameter int unsigned KBD_LINE   = 1,
  parameter int unsigned MOUSE_LINE = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPCI-1:0]       pci_int_n,
  input  logic [NPNP-1:0]       pnp_pin,
  input  logic [NPNP-1:0]       pnp_keep,
  input  logic [NUM_LINES-1:0]  ext_irq,
  input  logic [NUM_LINES-1:0]  ser_irq,
  input  logic [1:0]            kbd_emu_ret,
  output logic [NPCI-1:0]       pci_act,
  output logic [NPNP-1:0]       pnp_act,
  output logic [NUM_LINES-1:0]  legacy,
  output logic [1:0]            kbd_emu_src
);
  assign pci_act = ~pci_int_n;
  // keep bit clear: inverted path; set: polarity kept
  assign pnp_act = pnp_pin ^ ~pnp_keep;

  assign kbd_emu_src[0] = ext_irq[KBD_LINE]   & ser_irq[KBD_LINE];
  assign kbd_emu_src[1] = ext_irq[MOUSE_LINE] & ser_irq[MOUSE_LINE];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_leg
    if (g == KBD_LINE) begin : g_kbd
      assign legacy[g] = kbd_emu_ret[0];
    end else if (g == MOUSE_LINE) begin : g_mouse
      assign legacy[g] = kbd_emu_ret[1];
    end else begin : g_plain
      assign legacy[g] = ext_irq[g] | ser_irq[g];
    end
  end

  assert_kbd_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_emu_src[0] |-> (ext_irq[KBD_LINE] && ser_irq[KBD_LINE]));
endmodule

// File: rtl/irq_line_slot.sv
module irq_line_slot
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  line_cfg_t        cfg,
  input  logic             native_en,
  input  logic             drive_irq,
  input  logic [NPCI-1:0]  pci_act,
  input  logic [NPNP-1:0]  pnp_act,
  input  logic             sci,
  input  logic             legacy,
  output logic             req,
  output logic             level,
  output logic             act_low
);
  logic routed, hit;
  assign routed = is_routed(cfg);
  assign hit    = route_contrib(cfg, pci_act, pnp_act, sci);

  always_comb begin
    if (native_en) begin
      req     = ~(drive_irq | hit);
      level   = 1'b1;
      act_low = 1'b1;
    end else if (routed) begin
      req     = hit;
      level   = 1'b1;
      act_low = 1'b0;
    end else begin
      req     = legacy;
      level   = 1'b0;
      act_low = 1'b0;
    end
  end

  assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (routed && !native_en && !hit) |-> !req);
  assert_native_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (native_en && drive_irq) |-> (!req && act_low));
  assert_edge_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!routed && !native_en) |-> (!level && !act_low));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned NUM_NATIVE  = 2,
  parameter int unsigned NATIVE_BASE = 14,
  parameter int unsigned KBD_LINE    = 1,
  parameter int unsigned MOUSE_LINE  = 12,
  localparam int unsigned LINE_W     = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr_en,
  input  logic [LINE_W-1:0]      cfg_wr_line,
  input  logic [SEL_W-1:0]       cfg_wr_sel,
  input  logic                   cfg_wr_sci,
  input  logic                   nat_wr_en,
  input  logic [NUM_NATIVE-1:0]  nat_wr_val,
  input  logic [NPCI-1:0]        pci_int_n,
  input  logic [NPNP-1:0]        pnp_pin,
  input  logic [NPNP-1:0]        pnp_keep,
  input  logic                   sci_irq,
  input  logic [NUM_LINES-1:0]   ext_irq,
  input  logic [NUM_LINES-1:0]   ser_irq,
  input  logic [NUM_NATIVE-1:0]  drv_irq,
  input  logic [1:0]             kbd_emu_ret,
  output logic [1:0]             kbd_emu_src,
  output logic [NUM_LINES-1:0]   pic_req,
  output logic [NUM_LINES-1:0]   pic_level,
  output logic [NUM_LINES-1:0]   pic_act_low
);
  line_cfg_t [NUM_LINES-1:0] cfg_q;
  logic [NUM_NATIVE-1:0]     native_q;
  logic [NPCI-1:0]           pci_act;
  logic [NPNP-1:0]           pnp_act;
  logic [NUM_LINES-1:0]      legacy;
  line_cfg_t                 wr_cfg;

  assign wr_cfg = '{sci: cfg_wr_sci, sel: cfg_wr_sel};

  irq_cfg_regs #(.NUM_LINES(NUM_LINES), .NUM_NATIVE(NUM_NATIVE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_line(cfg_wr_line),
    .wr_cfg(wr_cfg), .nat_wr_en(nat_wr_en), .nat_wr_val(nat_wr_val),
    .cfg_q(cfg_q), .native_q(native_q));

  irq_src_cond #(.NUM_LINES(NUM_LINES), .KBD_LINE(KBD_LINE),
                 .MOUSE_LINE(MOUSE_LINE)) u_cond (
    .clk(clk), .rst_n(rst_n), .pci_int_n(pci_int_n), .pnp_pin(pnp_pin),
    .pnp_keep(pnp_keep), .ext_irq(ext_irq), .ser_irq(ser_irq),
    .kbd_emu_ret(kbd_emu_ret), .pci_act(pci_act), .pnp_act(pnp_act),
    .legacy(legacy), .kbd_emu_src(kbd_emu_src));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic nat_en, drv;
    if (g >= NATIVE_BASE && g < NATIVE_BASE + NUM_NATIVE) begin : g_nat
      localparam int unsigned K = g - NATIVE_BASE;
      assign nat_en = native_q[K];
      assign drv    = drv_irq[K];
    end else begin : g_std
      assign nat_en = 1'b0;
      assign drv    = 1'b0;
    end
    irq_line_slot u_slot (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[g]), .native_en(nat_en),
      .drive_irq(drv), .pci_act(pci_act), .pnp_act(pnp_act), .sci(sci_irq),
      .legacy(legacy[g]), .req(pic_req[g]), .level(pic_level[g]),
      .act_low(pic_act_low[g]));
  end
endmodule

// File: tb/irq_route_matrix_tb.sv
`timescale 1ns/1ps
module irq_route_matrix_tb;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_wr_en, cfg_wr_sci, nat_wr_en, sci_irq;
  logic [3:0] cfg_wr_line, pci_int_n;
  logic [2:0] cfg_wr_sel, pnp_pin, pnp_keep;
  logic [1:0] nat_wr_val, drv_irq, kbd_emu_ret, kbd_emu_src;
  logic [15:0] ext_irq, ser_irq, pic_req, pic_level, pic_act_low;

  irq_route_matrix u_dut (.*);

  typedef struct packed { logic [15:0] req, lvl, low; logic [1:0] kbd; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  event  ev;
  int    checks = 0, failures = 0;
  bit    finished = 0;

  int unsigned sh_sel[16];
  bit          sh_sci[16];
  bit [1:0]    sh_nat;

  function automatic exp_t model();
    exp_t e;
    for (int n = 0; n < 16; n++) begin
      bit leg, any, rt, nat;
      int unsigned s;
      if (n == 1) leg = kbd_emu_ret[0];
      else if (n == 12) leg = kbd_emu_ret[1];
      else leg = ext_irq[n] | ser_irq[n];
      s = sh_sel[n];
      any = sh_sci[n] && sci_irq;
      if (s >= 1 && s <= 4) any = any | !pci_int_n[s-1];
      if (s >= 5 && s <= 7) any = any | (pnp_keep[s-5] ? pnp_pin[s-5] : !pnp_pin[s-5]);
      rt  = (s != 0) || sh_sci[n];
      nat = (n >= 14) && sh_nat[n-14];
      e.req[n] = nat ? !(drv_irq[n-14] | any) : (rt ? any : leg);
      e.lvl[n] = nat | rt;
      e.low[n] = nat;
    end
    e.kbd = {ext_irq[12] & ser_irq[12], ext_irq[1] & ser_irq[1]};
    return e;
  endfunction

  task automatic check(string tag);
    #0.5;
    exp_q.push_back(model());
    tag_q.push_back(tag);
    -> ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(ev);
      #0.5;
      begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{req: pic_req, lvl: pic_level, low: pic_act_low, kbd: kbd_emu_src};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic cfg_write(int line, int sel, bit sci);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_line = 4'(line); cfg_wr_sel = 3'(sel); cfg_wr_sci = sci;
    @(negedge clk);
    cfg_wr_en = 0;
    sh_sel[line] = sel; sh_sci[line] = sci;
  endtask

  task automatic nat_write(bit [1:0] v);
    @(negedge clk);
    nat_wr_en = 1; nat_wr_val = v;
    @(negedge clk);
    nat_wr_en = 0; sh_nat = v;
  endtask

  task automatic clear_shadow();
    for (int i = 0; i < 16; i++) begin sh_sel[i] = 0; sh_sci[i] = 0; end
    sh_nat = 0;
  endtask

  initial begin : stim
    rst_n = 0; cfg_wr_en = 0; cfg_wr_sci = 0; nat_wr_en = 0; sci_irq = 0;
    cfg_wr_line = 0; cfg_wr_sel = 0; nat_wr_val = 0; pci_int_n = 4'hF;
    pnp_pin = 0; pnp_keep = 0; drv_irq = 0; kbd_emu_ret = 0;
    ext_irq = 0; ser_irq = 0;
    clear_shadow();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset state");
    @(negedge clk); ext_irq = 16'h8421; ser_irq = 16'h0310;
    check("R1 legacy pins pass");
    // keyboard/mouse merge
    @(negedge clk); ext_irq = 16'h1002; ser_irq = 16'h1002; kbd_emu_ret = 2'b00;
    check("R9 merge asserted, return low");
    @(negedge clk); kbd_emu_ret = 2'b10; ser_irq = 16'h0002;
    check("R9 partial merge, mouse return high");
    @(negedge clk); ext_irq = 0; ser_irq = 0; kbd_emu_ret = 0;
    // PCI A onto line 3, same cycle as its ext pin rising
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_line = 3; cfg_wr_sel = 1; cfg_wr_sci = 0; ext_irq[3] = 1;
    check("R7 before write edge: legacy still visible");
    @(negedge clk); cfg_wr_en = 0; sh_sel[3] = 1;
    check("R7 R2 after write edge: pin ignored");
    pci_int_n = 4'b1110; ext_irq[4] = 1;
    check("R3 PCI A low drives line 3; R2 line 4 untouched");
    cfg_write(5, 4, 0);
    @(negedge clk); pci_int_n = 4'b0111;
    check("R3 PCI D on line 5");
    // plug-and-play polarity
    cfg_write(9, 6, 0);
    @(negedge clk); pci_int_n = 4'hF; pnp_pin = 3'b000; pnp_keep = 3'b000;
    check("R4 keep clear, pin low -> line high");
    @(negedge clk); pnp_pin = 3'b010;
    check("R4 keep clear, pin high -> line low");
    @(negedge clk); pnp_keep = 3'b010;
    check("R4 keep set, pin high -> line high");
    @(negedge clk); pnp_pin = 0; pnp_keep = 3'b111;
    // system-control interrupt
    cfg_write(10, 0, 1);
    @(negedge clk); ext_irq[10] = 1; ser_irq[10] = 1; sci_irq = 0;
    check("R5 R7 sci low, legacy suppressed");
    @(negedge clk); sci_irq = 1;
    check("R5 sci high asserts line 10");
    // OR combination on line 11: pnp2 + sci
    cfg_write(11, 7, 1);
    @(negedge clk); sci_irq = 0; pnp_pin = 3'b100;
    check("R6 pnp alone");
    @(negedge clk); sci_irq = 1; pnp_pin = 0;
    check("R6 sci alone");
    @(negedge clk); sci_irq = 0;
    check("R6 neither");
    // native mode on line 14
    @(negedge clk); ext_irq[14] = 1;
    check("R1 line 14 legacy before native");
    nat_write(2'b01);
    check("R10 R8 native, drive idle, pin ignored");
    @(negedge clk); drv_irq = 2'b01;
    check("R8 drive asserted -> active low");
    @(negedge clk); drv_irq = 0; pci_int_n = 4'b1110;
    cfg_wr_en = 1; cfg_wr_line = 14; cfg_wr_sel = 1; cfg_wr_sci = 0;
    check("R8 before route write");
    @(negedge clk); cfg_wr_en = 0; sh_sel[14] = 1;
    check("R8 PCI A merged into native line");
    nat_write(2'b10);
    @(negedge clk); drv_irq = 2'b10; ext_irq[15] = 1;
    check("R10 R8 line 15 native, line 14 routed");
    // reset clears configuration
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; clear_shadow();
    check("R1 configuration cleared by reset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule